// File: doc/BRIEF.md
# Two-Wire EEPROM Byte Access Master

This block is the bus master for a configuration EEPROM on a two-wire serial bus. Software sets the command fields and pulses a start strobe. The block then carries out one transaction, either a single-byte write or a random single-byte read, and returns a sticky completion flag or a sticky bus-error flag.

The first byte of every frame holds a fixed 4-bit device-type prefix (a parameter, default 4'b1010), then the 3-bit slave select, then the direction bit. Both bus lines are open-drain. The block only pulls a line low or releases it. The line rate comes from a quarter-bit divider on the system clock.

During each acknowledge slot the block waits with the clock high. If the slave does not pull data low within a parameterised number of system clocks, the block abandons the cycle, issues a stop to free the bus, and raises the error flag.

Top module: `eeprom_byte_master`

## Requirements
- R1: A write command sends: start; address byte {device type, slave select, 0}; acknowledge slot; byte address, most significant bit first; acknowledge slot; data byte, most significant bit first; acknowledge slot; stop. This is 28 rising edges of the clock line in total.
- R2: A read command sends the address byte with direction bit 0, then the byte address, then a repeated start. Next it sends the address byte with direction bit 1 and gets an acknowledge. It then clocks in 8 bits, most significant bit first, which appear on `rd_data`. It ends with a not-acknowledge (data released) and a stop. This is 38 rising edges of the clock line in total.
- R3: `done` goes to 1 on the clock edge where `busy` falls after a transaction with no error. It stays 1 until the next accepted command.
- R4: Timing of an acknowledge slot starts once the clock line rises. If data is still high after `TIMEOUT` system clocks, `bus_err` becomes 1 and no further byte is sent. A stop is issued, the block returns to idle, and `done` stays 0.
- R5: While the clock line is high, the data line changes only to form a start, a repeated start or a stop.
- R6: A `cmd_start` pulse while `busy` is 1 is ignored. The running transaction is not changed and no second transaction follows.
- R7: After reset, and whenever idle, both lines are released and `busy` is 0. After reset, `done` and `bus_err` are 0.
- R8: `done` and `bus_err` are never both 1. Both are cleared on the cycle after a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | One-cycle command strobe, taken only while idle |
| cmd_read | input | 1 | 1 = random byte read, 0 = byte write |
| cmd_slave | input | 3 | Slave select placed after the device-type prefix |
| cmd_addr | input | 8 | Byte address inside the EEPROM |
| cmd_wdata | input | 8 | Byte to write |
| sda_in | input | 1 | Sampled level of the data line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky successful-completion flag |
| bus_err | output | 1 | Sticky acknowledge time-out flag |
| rd_data | output | 8 | Byte returned by the last successful read |
| scl_low | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_low | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The hardest state to reach is an acknowledge time-out. It needs a slave that stays silent while the master holds the clock high, and a check that the clock is then pulled low before the stop so that no false start appears on the bus. The bench has a behavioural slave that answers only its own select code, with acknowledges it can switch off. Random commands sometimes carry a wrong select code, and directed cases turn the slave's acknowledges off entirely. In each time-out case the bench counts how long the clock stayed high before the error, and checks the number of clock edges and the single stop that follow. A second command strobe in the middle of a frame is placed by a directed case.

// File: rtl/eeprom_byte_master.sv
module eeprom_byte_master #(
  parameter int DIV = 8,
  parameter int TIMEOUT = 256,
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_read,
  input  logic [2:0] cmd_slave,
  input  logic [7:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  input  logic       sda_in,
  output logic       busy,
  output logic       done,
  output logic       bus_err,
  output logic [7:0] rd_data,
  output logic       scl_low,
  output logic       sda_low
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [1:0] G_DEVW = 2'd0, G_ADDR = 2'd1, G_DATA = 2'd2, G_DEVR = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_ACK, S_RSTART, S_RX, S_NACK, S_STOP} st_t;

  st_t         st;
  logic [1:0]  ph, seg;
  logic [2:0]  bcnt;
  logic [DW-1:0] dcnt;
  logic [TW-1:0] tcnt;
  logic [7:0]  sh, addr_q, wdata_q;
  logic [2:0]  slv_q;
  logic        rd_q, scl_q, sda_q, done_q, err_q;

  wire tick = (dcnt == DW'(DIV - 1));

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign bus_err = err_q;
  assign scl_low = ~scl_q;
  assign sda_low = ~sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; seg <= '0; bcnt <= '0; dcnt <= '0; tcnt <= '0;
      sh <= '0; addr_q <= '0; wdata_q <= '0; slv_q <= '0; rd_q <= 1'b0;
      scl_q <= 1'b1; sda_q <= 1'b1; done_q <= 1'b0; err_q <= 1'b0; rd_data <= '0;
    end else if (st == S_IDLE) begin
      dcnt <= '0;
      if (cmd_start) begin
        rd_q <= cmd_read; slv_q <= cmd_slave; addr_q <= cmd_addr; wdata_q <= cmd_wdata;
        done_q <= 1'b0; err_q <= 1'b0; ph <= '0; st <= S_START;
      end
    end else begin
      dcnt <= tick ? '0 : dcnt + DW'(1);
      if (st == S_ACK && ph == 2'd2) begin
        if (!sda_in) ph <= 2'd3;
        else if (tcnt == TW'(TIMEOUT - 1)) begin err_q <= 1'b1; ph <= 2'd3; end
        else tcnt <= tcnt + TW'(1);
      end else if (tick) begin
        ph <= ph + 2'd1;
        case (ph)
          2'd0: case (st)
                  S_START: ;
                  S_STOP:  sda_q <= 1'b0;
                  S_TX:    sda_q <= sh[7];
                  default: sda_q <= 1'b1;
                endcase
          2'd1: begin
                  scl_q <= 1'b1;
                  tcnt  <= '0;
                end
          2'd2: case (st)
                  S_START, S_RSTART: sda_q <= 1'b0;
                  S_STOP:  sda_q <= 1'b1;
                  S_RX:    sh <= {sh[6:0], sda_in};
                  default: ;
                endcase
          default: begin
            if (st != S_STOP) scl_q <= 1'b0;
            case (st)
              S_START: begin st <= S_TX; sh <= {DEV_TYPE, slv_q, 1'b0}; seg <= G_DEVW; bcnt <= '0; end
              S_TX: begin
                sh <= {sh[6:0], 1'b0};
                bcnt <= bcnt + 3'd1;
                if (bcnt == 3'd7) st <= S_ACK;
              end
              S_ACK:
                if (err_q) st <= S_STOP;
                else case (seg)
                  G_DEVW: begin sh <= addr_q; seg <= G_ADDR; st <= S_TX; end
                  G_ADDR: if (rd_q) st <= S_RSTART;
                          else begin sh <= wdata_q; seg <= G_DATA; st <= S_TX; end
                  G_DATA: st <= S_STOP;
                  default: begin st <= S_RX; bcnt <= '0; end
                endcase
              S_RSTART: begin st <= S_TX; sh <= {DEV_TYPE, slv_q, 1'b1}; seg <= G_DEVR; end
              S_RX: begin
                bcnt <= bcnt + 3'd1;
                if (bcnt == 3'd7) st <= S_NACK;
              end
              S_NACK: st <= S_STOP;
              default: begin
                st <= S_IDLE;
                if (!err_q) begin
                  done_q <= 1'b1;
                  if (rd_q) rd_data <= sh;
                end
              end
            endcase
          end
        endcase
      end
    end
  end

  AST_SDA_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && (st inside {S_TX, S_ACK, S_RX, S_NACK})) |-> $stable(sda_q)) else $error("sda moved"); // R5
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (scl_q && sda_q)) else $error("bus held in idle"); // R7
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && err_q)) else $error("done and err together"); // R8
  AST_CLEAR_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && cmd_start) |=> (!done_q && !err_q && st == S_START)) else $error("flags not cleared"); // R8
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && cmd_start) |=> $stable({rd_q, slv_q, addr_q, wdata_q})) else $error("command taken while busy"); // R6
  AST_NO_TX_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && st != S_IDLE) |-> (st inside {S_ACK, S_STOP})) else $error("frame continued after time-out"); // R4
endmodule

// File: tb/test_eeprom_byte_master.sv
`timescale 1ns/1ps
module test_eeprom_byte_master;
  localparam int DIV = 4;
  localparam int TIMEOUT = 64;
  localparam logic [2:0] SLV_ID = 3'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_read = 1'b0;
  logic [2:0] cmd_slave = '0;
  logic [7:0] cmd_addr = '0, cmd_wdata = '0;
  logic busy, done, bus_err, scl_low, sda_low;
  logic [7:0] rd_data;
  logic slv_low = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = !scl_low;
  assign sda_w = !(sda_low || slv_low);

  always #4 clk = ~clk;

  eeprom_byte_master #(.DIV(DIV), .TIMEOUT(TIMEOUT), .DEV_TYPE(4'b1010)) i_eeprom_byte_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_read(cmd_read),
    .cmd_slave(cmd_slave), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .sda_in(sda_w),
    .busy(busy), .done(done), .bus_err(bus_err), .rd_data(rd_data),
    .scl_low(scl_low), .sda_low(sda_low));

  int vectors = 0, fails = 0, cyc = 0;

  // behavioural slave
  logic [7:0] sm [256];
  bit sm_init = 0;
  bit p_scl = 1, p_sda = 1, drive_ack = 0, ack_en = 1;
  int s_st = 0, bitc = 0, rbit = 0, n_dev = 0;
  int n_start = 0, n_stop = 0, n_sclr = 0, wr_cnt = 0, glitch = 0;
  logic [7:0] sh_s = '0, rdbyte = '0, ptr = '0, wr_addr = '0, wr_data = '0;
  logic [7:0] dev_log [2];

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  always @(scl_w or sda_w) begin
    if (!sm_init) begin
      for (int i = 0; i < 256; i++) sm[i] = init_val(i);
      sm_init = 1;
    end
    if (scl_w && p_scl && (sda_w != p_sda)) begin
      if (s_st == 4 || (s_st >= 1 && s_st <= 3 && bitc >= 2)) glitch++;
      if (!sda_w) begin n_start++; s_st = 1; bitc = 0; drive_ack = 0; end
      else begin n_stop++; s_st = 0; end
    end else if (scl_w && !p_scl) begin
      n_sclr++;
      if (!drive_ack && s_st != 0 && s_st != 4 && s_st != 5) begin sh_s = {sh_s[6:0], sda_w}; bitc++; end
    end else if (!scl_w && p_scl) begin
      if (drive_ack) begin
        drive_ack = 0; slv_low = 0;
        if (s_st == 4) begin rbit = 0; slv_low = !rdbyte[7]; end
      end else if (s_st == 4) begin
        if (rbit < 7) begin rbit++; slv_low = !rdbyte[7 - rbit]; end
        else begin slv_low = 0; s_st = 0; end
      end else if (bitc == 8) begin
        bitc = 0;
        case (s_st)
          1: begin
            if (n_dev < 2) dev_log[n_dev] = sh_s;
            n_dev++;
            if (ack_en && sh_s[7:1] == {4'b1010, SLV_ID}) begin
              slv_low = 1; drive_ack = 1;
              if (sh_s[0]) begin s_st = 4; rdbyte = sm[ptr]; end else s_st = 2;
            end else s_st = 0;
          end
          2: begin ptr = sh_s; slv_low = 1; drive_ack = 1; s_st = 3; end
          3: begin
            sm[ptr] = sh_s; wr_cnt++; wr_addr = ptr; wr_data = sh_s;
            slv_low = 1; drive_ack = 1; s_st = 5;
          end
          default: ;
        endcase
      end
    end
    p_scl = scl_w; p_sda = sda_w;
  end

  logic [7:0] exp_mem [256];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  int hi_cnt;

  task automatic run(input bit rd, input logic [2:0] s, input logic [7:0] a, input logic [7:0] d);
    bit ack;
    ack = ack_en && (s == SLV_ID);
    n_start = 0; n_stop = 0; n_sclr = 0; wr_cnt = 0; n_dev = 0; glitch = 0; hi_cnt = 0;
    @(negedge clk);
    cmd_read = rd; cmd_slave = s; cmd_addr = a; cmd_wdata = d; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    check("R8 flags cleared on accept", {busy, done, bus_err}, 3'b100);
    while (busy) begin
      @(negedge clk);
      if (scl_w && !bus_err && n_sclr == 9 && !ack) hi_cnt++;
    end
    check("R5 no sda change mid-byte", glitch, 0);
    if (ack) begin
      check("R3 done set", {done, bus_err}, 2'b10);
      check("R1 first address byte", dev_log[0], {4'b1010, s, 1'b0});
      if (rd) begin
        check("R2 read data", rd_data, exp_mem[a]);
        check("R2 second address byte", dev_log[1], {4'b1010, s, 1'b1});
        check("R2 starts", n_start, 2);
        check("R2 clock edges", n_sclr, 38);
        check("R2 no write", wr_cnt, 0);
      end else begin
        exp_mem[a] = d;
        check("R1 one write", wr_cnt, 1);
        check("R1 write addr/data", {wr_addr, wr_data}, {a, d});
        check("R1 clock edges", n_sclr, 28);
        check("R1 starts", n_start, 1);
      end
    end else begin
      check("R4 err set, done clear", {done, bus_err}, 2'b01);
      check("R4 clock edges", n_sclr, 10);
      check("R4 no write", wr_cnt, 0);
      check("R4 wait window", (hi_cnt >= TIMEOUT && hi_cnt <= TIMEOUT + 2 * DIV), 1);
    end
    check("R4 R1 R2 single stop", n_stop, 1);
    check("R7 lines released when idle", {scl_low, sda_low}, 2'b00);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    check("R7 reset state", {busy, done, bus_err, scl_low, sda_low}, 5'b0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R7 idle after reset", {busy, done, bus_err, scl_low, sda_low}, 5'b0);

    run(0, SLV_ID, 8'h00, 8'hff);
    run(1, SLV_ID, 8'h00, 8'h00);
    run(0, SLV_ID, 8'hff, 8'h00);
    run(1, SLV_ID, 8'hff, 8'h5a);
    run(1, SLV_ID, 8'h80, 8'h00);
    repeat (300) @(negedge clk);
    check("R3 done sticky", {done, bus_err}, 2'b10);

    run(0, 3'd2, 8'h10, 8'h33);
    repeat (300) @(negedge clk);
    check("R4 err sticky", {done, bus_err}, 2'b01);
    ack_en = 0;
    run(1, SLV_ID, 8'h10, 8'h00);
    ack_en = 1;
    run(1, SLV_ID, 8'h10, 8'h00);

    // R6: second strobe mid-frame
    n_start = 0; n_stop = 0; wr_cnt = 0; n_dev = 0;
    @(negedge clk);
    cmd_read = 0; cmd_slave = SLV_ID; cmd_addr = 8'h44; cmd_wdata = 8'h99; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    repeat (100) @(negedge clk);
    cmd_read = 1; cmd_slave = 3'd1; cmd_addr = 8'h20; cmd_start = 1;
    @(negedge clk); cmd_start = 0;
    while (busy) @(negedge clk);
    exp_mem[8'h44] = 8'h99;
    repeat (500) @(negedge clk);
    check("R6 busy strobe ignored", {busy, done, bus_err}, 3'b010);
    check("R6 one start one stop", {n_start[7:0], n_stop[7:0]}, 16'h0101);
    check("R6 original write kept", {wr_cnt[7:0], wr_addr, wr_data}, {8'd1, 8'h44, 8'h99});

    for (int k = 0; k < 36; k++) begin
      logic [2:0] s;
      s = ($urandom % 6 == 0) ? 3'($urandom) : SLV_ID;
      run(1'($urandom), s, 8'($urandom), 8'($urandom));
    end
    finish_run();
  end
endmodule